// File: doc/BRIEF.md
# Memory-Mapped Integer Divider

This block is a word-wide integer divide unit that sits behind a simple register bus. Software places a dividend and a divisor in two operand registers and then reads back a quotient and a remainder. Each operand register can be reached at two addresses. One address selects unsigned arithmetic and the other selects signed arithmetic. Any write to an operand address starts a new division in the mode that address names. The result appears a fixed number of cycles later.

A two-bit control/status word tells software when the result is valid. It also records whether the quotient has been read since the result arrived. Software can write the quotient and remainder registers directly, so an interrupted task can save the divider state and put it back later. The flags then look as if the restored result had just been computed. Division by zero does not trap; it returns defined values.

Top module: `mmio_divider`

## Requirements
- R1: After reset the dividend reads 0, the divisor reads 1, the quotient and remainder read 0, and the control/status word reads 1. In that word, bit 0 is READY and bit 1 is DIRTY.
- R2: The operand addresses are 0x60 and 0x68 for the dividend (unsigned, signed) and 0x64 and 0x6C for the divisor (unsigned, signed). Both addresses of an operand read the same stored value, whichever address last wrote it.
- R3: A write to any operand address starts a division. The control/status word then reads 0 through the 7th rising edge after the write edge, and reads 3 from the 8th rising edge on.
- R4: Unsigned mode (entered by a write to 0x60 or 0x64) gives the truncated quotient at 0x70 and the remainder at 0x74, with both operands taken as unsigned.
- R5: Signed mode (entered by a write to 0x68 or 0x6C) uses two's complement operands. The quotient is truncated toward zero and the remainder carries the sign of the dividend: 123456 / -321 gives -384 and 192, and 0x80000000 / 2 gives 0xC0000000 and 0.
- R6: An unsigned division by zero gives quotient 0xFFFFFFFF, and the remainder equals the dividend.
- R7: A signed division by zero gives quotient -1 when the dividend is above zero, and +1 when the dividend is zero or negative. The remainder equals the dividend.
- R8: A read of the quotient address clears DIRTY and leaves READY set, so the word then reads 1. A read of the remainder leaves both flags unchanged. DIRTY is never set while READY is clear.
- R9: A write to 0x70 or 0x74 loads that register with the written value and makes the control/status word read 3 from the next cycle. If a division is in progress, the write cancels it, so neither result register is overwritten later.
- R10: An operand write during a division restarts the computation with the updated operands. The result arrives 8 cycles after the latest operand write, and nothing is delivered at the time the earlier division would have finished.
- R11: While a division is in progress, reads of 0x70 and 0x74 return the previous result.
- R12: Reads of unmapped addresses return 0. Writes to unmapped addresses and to the control/status address 0x78 change no register and start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe; read side effects happen at the clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address while bus_rd is high, else 0 |

## Verification
The hardest situations to reach are the ones where bus traffic overlaps a division that is still running. These are a restore write that must cancel the pending result, a second operand write that must push completion back, and a result read that must still see the old values. The stimulus reaches them by issuing these accesses a chosen number of cycles after the launching write. It then polls the control/status word exactly at the cycle the cancelled or superseded division would have completed, and again at the cycle the surviving one does.

// File: rtl/divider_pkg.sv
// Shared constants and types for the memory-mapped divider.
// Assumes word-aligned byte addresses; offsets fit in 8 bits.
package divider_pkg;
    localparam logic [7:0] OFF_UDVD = 8'h60;
    localparam logic [7:0] OFF_UDVS = 8'h64;
    localparam logic [7:0] OFF_SDVD = 8'h68;
    localparam logic [7:0] OFF_SDVS = 8'h6C;
    localparam logic [7:0] OFF_QUO  = 8'h70;
    localparam logic [7:0] OFF_REM  = 8'h74;
    localparam logic [7:0] OFF_CSR  = 8'h78;

    typedef struct packed {
        logic dirty;
        logic ready;
    } div_flags_t;
endpackage

// File: rtl/divider_step.sv
// Combinational slice of a restoring divider: K shift-subtract stages unrolled.
// Assumes r_in < d on entry (or d == 0, whose result is overridden upstream).
module divider_step #(
    parameter int W = 32,
    parameter int K = 4
) (
    input  logic [W-1:0] r_in,
    input  logic [W-1:0] q_in,
    input  logic [W-1:0] d,
    output logic [W-1:0] r_out,
    output logic [W-1:0] q_out
);
    logic [W-1:0] r_s [K+1];
    logic [W-1:0] q_s [K+1];

    assign r_s[0] = r_in;
    assign q_s[0] = q_in;

    for (genvar i = 0; i < K; i++) begin : g_stage
        logic [W:0] trial;
        logic [W:0] diff;
        logic       fits;
        // Shift in the next dividend bit and try to subtract the divisor.
        always_comb begin
            trial = {r_s[i], q_s[i][W-1]};
            diff  = trial - {1'b0, d};
            fits  = trial >= {1'b0, d};
        end
        assign r_s[i+1] = fits ? diff[W-1:0] : trial[W-1:0];
        assign q_s[i+1] = {q_s[i][W-2:0], fits};
    end

    assign r_out = r_s[K];
    assign q_out = q_s[K];
endmodule

// File: rtl/divider_engine.sv
// Iterative divide engine: magnitude division over CYCLES cycles, then sign
// correction and divide-by-zero substitution. Assumes W is a multiple of CYCLES.
// start reloads the engine at any time; abort drops a running division.
module divider_engine #(
    parameter int W      = 32,
    parameter int CYCLES = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         start_sgn,
    input  logic [W-1:0] op_dvd,
    input  logic [W-1:0] op_dvs,
    input  logic         abort,
    output logic         done,
    output logic [W-1:0] res_quo,
    output logic [W-1:0] res_rem
);
    localparam int K     = W / CYCLES;
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     r_q, q_q, d_q, dvd_q;
    logic             sgn_q, dvd_neg_q, dvs_neg_q, dz_q;
    logic [W-1:0]     r_nx, q_nx;

    logic dvd_neg_in, dvs_neg_in;
    assign dvd_neg_in = start_sgn & op_dvd[W-1];
    assign dvs_neg_in = start_sgn & op_dvs[W-1];

    divider_step #(.W(W), .K(K)) u_step (
        .r_in (r_q),
        .q_in (q_q),
        .d    (d_q),
        .r_out(r_nx),
        .q_out(q_nx)
    );

    // Load magnitudes on start, then advance K quotient bits per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            cnt_q     <= '0;
            r_q       <= '0;
            q_q       <= '0;
            d_q       <= '0;
            dvd_q     <= '0;
            sgn_q     <= 1'b0;
            dvd_neg_q <= 1'b0;
            dvs_neg_q <= 1'b0;
            dz_q      <= 1'b0;
        end else if (start) begin
            busy_q    <= 1'b1;
            cnt_q     <= '0;
            r_q       <= '0;
            q_q       <= dvd_neg_in ? (~op_dvd + 1'b1) : op_dvd;
            d_q       <= dvs_neg_in ? (~op_dvs + 1'b1) : op_dvs;
            dvd_q     <= op_dvd;
            sgn_q     <= start_sgn;
            dvd_neg_q <= dvd_neg_in;
            dvs_neg_q <= dvs_neg_in;
            dz_q      <= (op_dvs == '0);
        end else if (abort) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            r_q   <= r_nx;
            q_q   <= q_nx;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) busy_q <= 1'b0;
        end
    end

    assign done = busy_q && (cnt_q == LAST);

    // Final result: sign fix-up, or the fixed divide-by-zero values.
    always_comb begin
        if (dz_q) begin
            res_rem = dvd_q;
            if (sgn_q && (dvd_q[W-1] || dvd_q == '0)) res_quo = W'(1);
            else                                      res_quo = '1;
        end else begin
            res_quo = (dvd_neg_q ^ dvs_neg_q) ? (~q_nx + 1'b1) : q_nx;
            res_rem = dvd_neg_q ? (~r_nx + 1'b1) : r_nx;
        end
    end
endmodule

// File: rtl/mmio_divider.sv
// Register front end of the divider: aliased operand registers, result
// registers, and READY/DIRTY flags. Assumes at most one access of each kind
// per cycle and word-aligned addresses; read data is combinational.
module mmio_divider #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int LATENCY = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    import divider_pkg::*;

    logic [DATA_W-1:0] dvd_q, dvs_q, quo_q, rem_q;
    div_flags_t        flags_q;
    logic              ready_q, dirty_q;
    logic              eng_done;
    logic [DATA_W-1:0] eng_quo, eng_rem;

    logic wr_udvd, wr_sdvd, wr_udvs, wr_sdvs, wr_quo, wr_rem;
    logic wr_dvd, wr_dvs, op_wr, res_wr, rd_quo, take;
    logic [DATA_W-1:0] new_dvd, new_dvs;

    // Decode bus writes and reads that carry side effects.
    always_comb begin
        wr_udvd = bus_wr && (bus_addr == ADDR_W'(OFF_UDVD));
        wr_sdvd = bus_wr && (bus_addr == ADDR_W'(OFF_SDVD));
        wr_udvs = bus_wr && (bus_addr == ADDR_W'(OFF_UDVS));
        wr_sdvs = bus_wr && (bus_addr == ADDR_W'(OFF_SDVS));
        wr_quo  = bus_wr && (bus_addr == ADDR_W'(OFF_QUO));
        wr_rem  = bus_wr && (bus_addr == ADDR_W'(OFF_REM));
        rd_quo  = bus_rd && (bus_addr == ADDR_W'(OFF_QUO));
        wr_dvd  = wr_udvd | wr_sdvd;
        wr_dvs  = wr_udvs | wr_sdvs;
        op_wr   = wr_dvd | wr_dvs;
        res_wr  = wr_quo | wr_rem;
        new_dvd = wr_dvd ? bus_wdata : dvd_q;
        new_dvs = wr_dvs ? bus_wdata : dvs_q;
        take    = eng_done && !op_wr && !res_wr;
    end

    divider_engine #(.W(DATA_W), .CYCLES(LATENCY)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (op_wr),
        .start_sgn(wr_sdvd | wr_sdvs),
        .op_dvd   (new_dvd),
        .op_dvs   (new_dvs),
        .abort    (res_wr),
        .done     (eng_done),
        .res_quo  (eng_quo),
        .res_rem  (eng_rem)
    );

    // Operand registers shared by the signed and unsigned aliases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q <= '0;
            dvs_q <= DATA_W'(1);
        end else begin
            dvd_q <= new_dvd;
            dvs_q <= new_dvs;
        end
    end

    // Result registers: loaded by software restore or by a finished division.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
        end else begin
            if (wr_quo)    quo_q <= bus_wdata;
            else if (take) quo_q <= eng_quo;
            if (wr_rem)    rem_q <= bus_wdata;
            else if (take) rem_q <= eng_rem;
        end
    end

    // Status flags: launch clears both, result or restore sets both, quotient read clears DIRTY.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '{dirty: 1'b0, ready: 1'b1};
        end else if (op_wr) begin
            flags_q <= '{dirty: 1'b0, ready: 1'b0};
        end else if (res_wr || take) begin
            flags_q <= '{dirty: 1'b1, ready: 1'b1};
        end else if (rd_quo) begin
            flags_q.dirty <= 1'b0;
        end
    end

    assign ready_q = flags_q.ready;
    assign dirty_q = flags_q.dirty;

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                ADDR_W'(OFF_UDVD), ADDR_W'(OFF_SDVD): bus_rdata = dvd_q;
                ADDR_W'(OFF_UDVS), ADDR_W'(OFF_SDVS): bus_rdata = dvs_q;
                ADDR_W'(OFF_QUO):                     bus_rdata = quo_q;
                ADDR_W'(OFF_REM):                     bus_rdata = rem_q;
                ADDR_W'(OFF_CSR): bus_rdata = {{(DATA_W-2){1'b0}}, dirty_q, ready_q};
                default:                              bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/divider_chk.sv
// Protocol checks for mmio_divider, attached by bind. Observes bus ports,
// the flag state and the engine completion strobe.
module divider_chk #(
    parameter int ADDR_W  = 8,
    parameter int LATENCY = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              ready,
    input logic              dirty,
    input logic              eng_done
);
    import divider_pkg::*;

    localparam int CW = $clog2(LATENCY + 2);

    logic op_wr, res_wr, rd_quo, mapped_wr;
    logic [CW-1:0] since_wr;

    always_comb begin
        op_wr  = bus_wr && (bus_addr == ADDR_W'(OFF_UDVD) || bus_addr == ADDR_W'(OFF_SDVD) ||
                            bus_addr == ADDR_W'(OFF_UDVS) || bus_addr == ADDR_W'(OFF_SDVS));
        res_wr = bus_wr && (bus_addr == ADDR_W'(OFF_QUO) || bus_addr == ADDR_W'(OFF_REM));
        rd_quo = bus_rd && (bus_addr == ADDR_W'(OFF_QUO));
        mapped_wr = op_wr || res_wr;
    end

    // Cycles since the latest operand write, saturating past the latency.
    always_ff @(posedge clk) begin
        if (!rst_n)                    since_wr <= CW'(LATENCY + 1);
        else if (op_wr)                since_wr <= CW'(1);
        else if (since_wr <= CW'(LATENCY)) since_wr <= since_wr + 1'b1;
    end

    // R3
    launch_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_wr |=> !ready);

    // R3
    finish_sets_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !bus_wr) |=> (ready && dirty));

    // R10
    finish_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |-> (since_wr == CW'(LATENCY)));

    // R9
    restore_sets_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr |=> (ready && dirty));

    // R8
    quo_read_clears_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_quo && !bus_wr && !eng_done) |=> !dirty);

    // R8
    dirty_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dirty |-> ready);

    // R12
    unmapped_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !mapped_wr && !eng_done && !rd_quo) |=> ($stable(ready) && $stable(dirty)));
endmodule

bind mmio_divider divider_chk #(.ADDR_W(ADDR_W), .LATENCY(LATENCY)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_addr(bus_addr),
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .ready   (ready_q),
    .dirty   (dirty_q),
    .eng_done(eng_done)
);

// File: tb/tb_mmio_divider.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected words, a negedge monitor compares.
module tb_mmio_divider;
    localparam logic [7:0] A_UDVD = 8'h60, A_UDVS = 8'h64, A_SDVD = 8'h68, A_SDVS = 8'h6C;
    localparam logic [7:0] A_QUO = 8'h70, A_REM = 8'h74, A_CSR = 8'h78;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    mmio_divider dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Monitor: compare each read against the front of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && bus_rd) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read: actual %08h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual %08h expected %08h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    function automatic void ref_div(input bit sgn, input logic [31:0] a, input logic [31:0] b,
                                    output logic [31:0] q, output logic [31:0] r);
        if (b == 0) begin
            r = a;
            if (sgn && !($signed(a) > 0)) q = 32'd1;
            else                          q = 32'hFFFF_FFFF;
        end else if (sgn) begin
            q = $signed(a) / $signed(b);
            r = $signed(a) % $signed(b);
        end else begin
            q = a / b;
            r = a % b;
        end
    endfunction

    // Driver: launch a division, check READY timing, then the results and flags.
    task automatic do_div(input bit sgn, input logic [31:0] a, input logic [31:0] b, input string t);
        logic [31:0] q, r;
        ref_div(sgn, a, b, q, r);
        wr(sgn ? A_SDVD : A_UDVD, a);
        wr(sgn ? A_SDVS : A_UDVS, b);
        idle(7);
        rd(A_CSR, 32'd0, {t, " R3 busy at edge 7"});
        rd(A_CSR, 32'd3, {t, " R3 ready at edge 8"});
        rd(A_REM, r, {t, " remainder"});
        rd(A_CSR, 32'd3, {t, " R8 remainder read keeps flags"});
        rd(A_QUO, q, {t, " quotient"});
        rd(A_CSR, 32'd1, {t, " R8 quotient read clears dirty"});
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset values, R2 aliases
        rd(A_CSR, 32'd1, "R1 csr");
        rd(A_UDVD, 32'd0, "R1 R2 dividend u");
        rd(A_SDVD, 32'd0, "R1 R2 dividend s");
        rd(A_UDVS, 32'd1, "R1 R2 divisor u");
        rd(A_SDVS, 32'd1, "R1 R2 divisor s");
        rd(A_QUO, 32'd0, "R1 quotient");
        rd(A_REM, 32'd0, "R1 remainder");

        // R5 signed cases
        do_div(1'b1, 32'd123456, -32'sd321, "R5 123456/-321");
        do_div(1'b1, -32'sd3000, 32'd2, "R5 -3000/2");
        do_div(1'b1, 32'h8000_0000, 32'd2, "R5 min/2");
        do_div(1'b1, -32'sd7, -32'sd2, "R5 -7/-2");
        // R4 unsigned cases
        do_div(1'b0, 32'd123456, 32'd321, "R4 123456/321");
        do_div(1'b0, 32'h8000_0000, 32'd2, "R4 0x80000000/2");
        do_div(1'b0, 32'hFFFF_FFFF, 32'd7, "R4 max/7");
        // R6 and R7 divide by zero
        do_div(1'b0, 32'd123456, 32'd0, "R6 123456/0");
        do_div(1'b0, 32'h8000_0000, 32'd0, "R6 0x80000000/0");
        do_div(1'b0, 32'd0, 32'd0, "R6 0/0");
        do_div(1'b1, 32'd3000, 32'd0, "R7 3000/0");
        do_div(1'b1, -32'sd3000, 32'd0, "R7 -3000/0");
        do_div(1'b1, 32'd0, 32'd0, "R7 0/0");

        // R2 alias read of values written through the other address
        wr(A_SDVD, 32'hDEAD_0001);
        rd(A_UDVD, 32'hDEAD_0001, "R2 dividend alias");
        wr(A_UDVS, 32'h0000_0123);
        rd(A_SDVS, 32'h0000_0123, "R2 divisor alias");
        idle(8);

        // R11 reads during a division return the previous result
        do_div(1'b0, 32'd123, 32'd7, "R4 123/7");
        wr(A_UDVD, 32'd1000);
        wr(A_UDVS, 32'd10);
        rd(A_QUO, 32'd17, "R11 quotient while busy");
        rd(A_REM, 32'd4, "R11 remainder while busy");
        idle(5);
        rd(A_CSR, 32'd0, "R11 still busy");
        rd(A_CSR, 32'd3, "R11 finished");
        rd(A_QUO, 32'd100, "R11 new quotient");

        // R10 restart during a division
        wr(A_UDVD, 32'd1000);
        wr(A_UDVS, 32'd10);
        idle(3);
        wr(A_UDVD, 32'd5000);
        idle(3);
        rd(A_CSR, 32'd0, "R10 busy before original end");
        rd(A_CSR, 32'd0, "R10 nothing at original end");
        idle(2);
        rd(A_CSR, 32'd0, "R10 busy edge 7 after restart");
        rd(A_CSR, 32'd3, "R10 ready edge 8 after restart");
        rd(A_QUO, 32'd500, "R10 restarted quotient");

        // R9 restore and cancel
        wr(A_REM, 32'h0000_ABCD);
        rd(A_CSR, 32'd3, "R9 restore sets flags");
        rd(A_REM, 32'h0000_ABCD, "R9 restored remainder");
        wr(A_SDVD, 32'd50);
        wr(A_SDVS, 32'd5);
        idle(2);
        wr(A_QUO, 32'hFFFF_FE80);
        rd(A_CSR, 32'd3, "R9 restore during busy");
        idle(10);
        rd(A_QUO, 32'hFFFF_FE80, "R9 cancelled result kept quotient");
        rd(A_REM, 32'h0000_ABCD, "R9 cancelled result kept remainder");
        rd(A_CSR, 32'd1, "R9 flags after quotient read");

        // R12 unmapped and status writes are inert
        wr(8'h7C, 32'hFFFF_FFFF);
        rd(A_CSR, 32'd1, "R12 unmapped write starts nothing");
        rd(8'h7C, 32'd0, "R12 unmapped read");
        rd(8'h00, 32'd0, "R12 unmapped read low");
        wr(A_CSR, 32'd0);
        rd(A_CSR, 32'd1, "R12 status write ignored");
        idle(9);
        rd(A_CSR, 32'd1, "R12 no late completion");
        rd(A_QUO, 32'hFFFF_FE80, "R12 quotient untouched");
        rd(A_UDVD, 32'd50, "R12 dividend untouched");

        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule